// File: doc/BRIEF.md
# Storage Key Protection Checker

This block guards real memory one 4 KB frame at a time. Each frame has a small key entry. The entry holds a 4-bit access-control key, a fetch-protect flag, a referenced flag and a changed flag. Every memory access arrives with a real address, a read/write direction and the requester's access key. The block looks up the frame's entry and decides whether to grant the access or raise a protection exception. When it grants an access, it records the use in the referenced and changed flags.

A second port lets software manage the key array. Through it, software can load a complete entry, read an entry back, or clear the referenced flag of a frame, for example when it ages pages. The check result appears one clock after the request. It is registered together with the entry as it stands after that cycle's update.

Top module: `skp_checker`

## Requirements
- R1: After reset, every entry is zero, and rsp_valid, rsp_grant, rsp_exc and rsp_entry are all low.
- R2: An entry is 7 bits, laid out as key[6:3], fetch-protect[2], referenced[1], changed[0]. The frame index is req_addr[ADDR_W-1:12], so the low 12 address bits do not select the entry. sw_op 1 stores sw_wdata into frame sw_page. sw_op 0 reads that frame. On sw_rdata, one cycle later, every software operation returns the entry as it stood before the operation.
- R3: A request with access key 0 is granted for both reads and writes, whatever key the frame holds.
- R4: A request whose key equals the frame's key is granted for both reads and writes.
- R5: A write whose nonzero key differs from the frame's key raises an exception.
- R6: A read whose nonzero key differs from the frame's key is granted when fetch-protect is 0 and raises an exception when fetch-protect is 1.
- R7: A granted access sets the referenced bit. A granted write also sets the changed bit. rsp_entry shows the resulting entry.
- R8: A refused access leaves the entry unchanged, and rsp_entry shows it unchanged.
- R9: sw_op 2 clears the referenced bit of frame sw_page and keeps its key, fetch-protect and changed bits.
- R10: A software write or referenced-clear to the same frame as a request in the same cycle takes priority. The frame then holds the software result, and rsp_entry shows it. The grant decision still uses the entry as it stood before that cycle. A software operation on a different frame does not disturb the hardware update.
- R11: rsp_valid is high exactly in the cycle after a cycle with req_valid high. When it is high, exactly one of rsp_grant and rsp_exc is high. When it is low, rsp_grant, rsp_exc and rsp_entry are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Real address of the access |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_key | input | 4 | Requester access key |
| rsp_valid | output | 1 | Check result present |
| rsp_grant | output | 1 | Access permitted |
| rsp_exc | output | 1 | Protection exception |
| rsp_entry | output | 7 | Frame entry after this access |
| sw_valid | input | 1 | Software operation present |
| sw_op | input | 2 | 0 read, 1 write entry, 2 clear referenced, 3 no-op |
| sw_page | input | ADDR_W-12 | Frame index for the software operation |
| sw_wdata | input | 7 | Entry value for a software write |
| sw_rdata | output | 7 | Entry before the last software operation |

## Verification
The bench sends master-key writes, matching-key reads and writes, and mismatched stores and fetches against frames with fetch-protect both clear and set. A design that confuses the fetch-protect polarity, or that blocks key 0, shows the wrong grant/exception pair. Refused accesses are followed by software readback, so a design that sets the referenced bit even on a refusal is caught. Same-frame collisions between software and hardware expose a design in which the hardware flag update overwrites the software value. A collision on neighbouring frames exposes an index compare that is too loose.

// File: rtl/skp_pkg.sv
package skp_pkg;
    localparam int KEY_W   = 4;
    localparam int ENTRY_W = KEY_W + 3;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             fetch_prot;
        logic             referenced;
        logic             changed;
    } skey_t;

    typedef enum logic [1:0] {
        SW_READ    = 2'd0,
        SW_WRITE   = 2'd1,
        SW_CLR_REF = 2'd2,
        SW_NOP     = 2'd3
    } sw_op_e;
endpackage

// File: rtl/skp_decide.sv
module skp_decide
    import skp_pkg::*;
(
    input  skey_t            cur,
    input  logic             is_write,
    input  logic [KEY_W-1:0] req_key,
    output logic             grant,
    output skey_t            upd
);
    logic key_ok;

    always_comb begin
        key_ok = (req_key == '0) || (req_key == cur.key);
        if (key_ok)        grant = 1'b1;
        else if (is_write) grant = 1'b0;
        else               grant = ~cur.fetch_prot;

        upd = cur;
        if (grant) begin
            upd.referenced = 1'b1;
            if (is_write) upd.changed = 1'b1;
        end
    end
endmodule

// File: rtl/skp_key_array.sv
module skp_key_array
    import skp_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int PAGES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] hw_idx,
    input  logic             hw_we,
    input  skey_t            hw_data,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic             sw_we,
    input  skey_t            sw_data,
    output skey_t            hw_rd,
    output skey_t            sw_rd
);
    skey_t mem_q [PAGES];
    skey_t mem_d [PAGES];

    always_comb begin
        mem_d = mem_q;
        if (hw_we) mem_d[hw_idx] = hw_data;
        // software lands last so it wins on a shared frame
        if (sw_we) mem_d[sw_idx] = sw_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign hw_rd = mem_q[hw_idx];
    assign sw_rd = mem_q[sw_idx];
endmodule

// File: rtl/skp_checker.sv
module skp_checker
    import skp_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [KEY_W-1:0]   req_key,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_exc,
    output logic [ENTRY_W-1:0] rsp_entry,
    input  logic               sw_valid,
    input  logic [1:0]         sw_op,
    input  logic [IDX_W-1:0]   sw_page,
    input  logic [ENTRY_W-1:0] sw_wdata,
    output logic [ENTRY_W-1:0] sw_rdata
);
    typedef struct packed {
        logic  rsp_valid;
        logic  grant;
        logic  exc;
        skey_t entry;
        skey_t sw_rdata;
    } state_t;

    state_t state_d, state_q;

    logic [IDX_W-1:0] hw_idx;
    skey_t            hw_rd, sw_rd, upd, sw_data;
    logic             grant, hw_we, sw_we, collide;
    sw_op_e           op;

    assign hw_idx = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign op     = sw_op_e'(sw_op);

    skp_decide u_decide (
        .cur      (hw_rd),
        .is_write (req_write),
        .req_key  (req_key),
        .grant    (grant),
        .upd      (upd)
    );

    skp_key_array #(.IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_idx  (hw_idx),
        .hw_we   (hw_we),
        .hw_data (upd),
        .sw_idx  (sw_page),
        .sw_we   (sw_we),
        .sw_data (sw_data),
        .hw_rd   (hw_rd),
        .sw_rd   (sw_rd)
    );

    always_comb begin
        sw_we   = sw_valid && (op == SW_WRITE || op == SW_CLR_REF);
        sw_data = sw_rd;
        if (op == SW_WRITE) sw_data = skey_t'(sw_wdata);
        else                sw_data.referenced = 1'b0;
        hw_we   = req_valid && grant;
        collide = sw_we && (sw_page == hw_idx);

        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.grant     = req_valid && grant;
        state_d.exc       = req_valid && !grant;
        if (!req_valid)   state_d.entry = '0;
        else if (collide) state_d.entry = sw_data;
        else              state_d.entry = upd;
        if (sw_valid && op != SW_NOP) state_d.sw_rdata = sw_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_grant = state_q.grant;
    assign rsp_exc   = state_q.exc;
    assign rsp_entry = state_q.entry;
    assign sw_rdata  = state_q.sw_rdata;
endmodule

// File: rtl/skp_checker_sva.sv
module skp_checker_sva
    import skp_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_write,
    input logic [KEY_W-1:0]   req_key,
    input logic               rsp_valid,
    input logic               rsp_grant,
    input logic               rsp_exc,
    input logic [ENTRY_W-1:0] rsp_entry,
    input logic               sw_valid,
    input logic [1:0]         sw_op,
    input logic [IDX_W-1:0]   sw_page
);
    logic sw_hits;
    assign sw_hits = sw_valid && (sw_op == 2'd1 || sw_op == 2'd2)
                     && (sw_page == req_addr[ADDR_W-1:PAGE_SHIFT]);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant != rsp_exc)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_exc && rsp_entry == '0)); // R11
    AST_MASTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_key == '0) |=> rsp_grant); // R3
    AST_GRANT_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sw_hits) |=> (!rsp_grant || rsp_entry[1])); // R7
    AST_STORE_MARKS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !sw_hits) |=> (!rsp_grant || rsp_entry[0])); // R7
endmodule

bind skp_checker skp_checker_sva #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_key   (req_key),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_exc   (rsp_exc),
    .rsp_entry (rsp_entry),
    .sw_valid  (sw_valid),
    .sw_op     (sw_op),
    .sw_page   (sw_page)
);

// File: tb/skp_checker_bench.sv
module skp_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int IDX_W      = ADDR_W - 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [3:0]        req_key = '0;
    logic              rsp_valid, rsp_grant, rsp_exc;
    logic [6:0]        rsp_entry, sw_rdata;
    logic              sw_valid = 1'b0;
    logic [1:0]        sw_op = 2'd3;
    logic [IDX_W-1:0]  sw_page = '0;
    logic [6:0]        sw_wdata = '0;

    int checks = 0;
    int errors = 0;

    logic       got_v, got_g, got_e;
    logic [6:0] got_ent, got_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    skp_checker #(.ADDR_W(ADDR_W)) u_skp_checker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_key(req_key),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_exc(rsp_exc), .rsp_entry(rsp_entry),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_page(sw_page), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic capture();
        got_v = rsp_valid; got_g = rsp_grant; got_e = rsp_exc;
        got_ent = rsp_entry; got_rd = sw_rdata;
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic w, input logic [3:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_key = k;
        @(negedge clk);
        req_valid = 1'b0;
        capture();
        check(got_v == 1'b1, "R11 valid after request", got_v, 1);
    endtask

    task automatic sw(input logic [1:0] op, input logic [IDX_W-1:0] pg, input logic [6:0] d);
        @(negedge clk);
        sw_valid = 1'b1; sw_op = op; sw_page = pg; sw_wdata = d;
        @(negedge clk);
        sw_valid = 1'b0; sw_op = 2'd3;
        capture();
    endtask

    task automatic both(input logic [ADDR_W-1:0] a, input logic w, input logic [3:0] k,
                        input logic [1:0] op, input logic [IDX_W-1:0] pg, input logic [6:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_key = k;
        sw_valid = 1'b1; sw_op = op; sw_page = pg; sw_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; sw_valid = 1'b0; sw_op = 2'd3;
        capture();
    endtask

    function automatic logic [ADDR_W-1:0] pa(input int page, input int off);
        return ADDR_W'(page * 4096 + off);
    endfunction

    task automatic t_reset();
        capture();
        check(!got_v && !got_g && !got_e && got_ent == 0, "R1 outputs idle", {got_v, got_g, got_e}, 0);
        sw(2'd0, 6'd5, 7'h00);
        check(got_rd == 7'h00, "R1 entry cleared", got_rd, 0);
    endtask

    task automatic t_sw_rw();
        sw(2'd1, 6'd3, 7'h2C);
        sw(2'd0, 6'd3, 7'h00);
        check(got_rd == 7'h2C, "R2 write then read", got_rd, 7'h2C);
        sw(2'd0, 6'd4, 7'h00);
        check(got_rd == 7'h00, "R2 neighbour untouched", got_rd, 0);
    endtask

    task automatic t_key0();
        access(pa(3, 12'hABC), 1'b1, 4'd0);
        check(got_g && !got_e, "R3 key zero store granted", {got_g, got_e}, 2'b10);
        check(got_ent == 7'h2F, "R7 R and C set (R2 index)", got_ent, 7'h2F);
    endtask

    task automatic t_match();
        sw(2'd1, 6'd7, 7'h48);
        access(pa(7, 12'h010), 1'b0, 4'd9);
        check(got_g && !got_e, "R4 matching fetch granted", {got_g, got_e}, 2'b10);
        check(got_ent == 7'h4A, "R7 fetch sets R only", got_ent, 7'h4A);
        access(pa(7, 12'hFFF), 1'b1, 4'd9);
        check(got_g && !got_e, "R4 matching store granted", {got_g, got_e}, 2'b10);
        check(got_ent == 7'h4B, "R7 store sets C", got_ent, 7'h4B);
    endtask

    task automatic t_store_mismatch();
        sw(2'd1, 6'd8, 7'h10);
        access(pa(8, 0), 1'b1, 4'd4);
        check(!got_g && got_e, "R5 mismatched store refused", {got_g, got_e}, 2'b01);
        check(got_ent == 7'h10, "R8 refused entry unchanged", got_ent, 7'h10);
        sw(2'd0, 6'd8, 7'h00);
        check(got_rd == 7'h10, "R8 readback after refusal", got_rd, 7'h10);
    endtask

    task automatic t_fetch();
        access(pa(8, 12'h123), 1'b0, 4'd4);
        check(got_g && !got_e, "R6 unprotected fetch granted", {got_g, got_e}, 2'b10);
        check(got_ent == 7'h12, "R7 fetch sets R", got_ent, 7'h12);
        sw(2'd1, 6'd9, 7'h14);
        access(pa(9, 12'h040), 1'b0, 4'd4);
        check(!got_g && got_e, "R6 protected fetch refused", {got_g, got_e}, 2'b01);
        sw(2'd0, 6'd9, 7'h00);
        check(got_rd == 7'h14, "R8 protected frame unchanged", got_rd, 7'h14);
    endtask

    task automatic t_clr_ref();
        sw(2'd2, 6'd7, 7'h00);
        check(got_rd == 7'h4B, "R2 clear returns prior entry", got_rd, 7'h4B);
        sw(2'd0, 6'd7, 7'h00);
        check(got_rd == 7'h49, "R9 only R cleared", got_rd, 7'h49);
    endtask

    task automatic t_collide();
        both(pa(10, 12'h008), 1'b1, 4'd0, 2'd1, 6'd10, 7'h2C);
        check(got_g && !got_e, "R10 grant from prior entry", {got_g, got_e}, 2'b10);
        check(got_ent == 7'h2C, "R10 response shows software value", got_ent, 7'h2C);
        sw(2'd0, 6'd10, 7'h00);
        check(got_rd == 7'h2C, "R10 software value kept", got_rd, 7'h2C);
        both(pa(11, 0), 1'b1, 4'd0, 2'd1, 6'd12, 7'h48);
        check(got_ent == 7'h03, "R10 other frame hw update", got_ent, 7'h03);
        sw(2'd0, 6'd11, 7'h00);
        check(got_rd == 7'h03, "R10 hw frame stored", got_rd, 7'h03);
        sw(2'd0, 6'd12, 7'h00);
        check(got_rd == 7'h48, "R10 sw frame stored", got_rd, 7'h48);
        both(pa(7, 0), 1'b0, 4'd9, 2'd2, 6'd7, 7'h00);
        check(got_ent == 7'h49, "R10 clear beats hw R set", got_ent, 7'h49);
    endtask

    task automatic t_idle();
        access(pa(3, 0), 1'b0, 4'd5);
        @(negedge clk);
        capture();
        check(!got_v && !got_g && !got_e && got_ent == 0, "R11 idle after one response",
              {got_v, got_g, got_e}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_rw();
        t_key0();
        t_match();
        t_store_mismatch();
        t_fetch();
        t_clr_ref();
        t_collide();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule